// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table that sits in memory. A request splits the address into three fields, from the top bit down: a 10-bit directory index, a 10-bit table index and a 12-bit page offset. Pages are 4096 bytes, and every table holds 1024 entries of 4 bytes each.

The walk always starts from a frame register that software loads while the walker is idle. The first memory read fetches the directory entry. When that entry is valid, its frame number locates the second-level table, and a second read fetches the leaf entry. A valid leaf entry gives the physical address, which is the leaf's frame number followed by the untouched page offset. An entry with its valid bit clear at either level ends the walk with a fault. A single-cycle done strobe reports either result.

The walker handles one walk at a time. A request is accepted only while `req_ready_o` is high. Memory reads use a level request that is held until a response strobe arrives, so any memory latency is allowed.

Top module: `pt_walker`

## Requirements
- R1: The first read goes to address (base_frame << 12) + dir_idx * 4. Here dir_idx is vaddr[31:22], and base_frame is bits [31:12] of the last accepted base write. Bits [11:0] of a base write are discarded.
- R2: When the directory entry has bit 0 set, the second read goes to address (entry[31:12] << 12) + tbl_idx * 4, where tbl_idx is vaddr[21:12].
- R3: When the leaf entry has bit 0 set, the done strobe comes with fault_o = 0 and paddr_o = {leaf[31:12], vaddr[11:0]}.
- R4: When the directory entry has bit 0 clear, the walk ends with fault_o = 1 and no second read is issued, so the walk makes exactly one memory read.
- R5: When the leaf entry has bit 0 clear, the walk ends with fault_o = 1. Whenever fault_o is 1, paddr_o reads 0.
- R6: done_o is high for exactly one cycle per walk, in the cycle after the response that ends the walk. fault_o is 0 whenever done_o is 0.
- R7: req_ready_o is high only when the walker is idle. A request is taken only while req_ready_o is high, and a request raised during a walk changes neither the result nor the number of reads.
- R8: A base write while the walker is idle applies to the next walk. A base write during a walk is ignored.
- R9: After reset the walker is idle with done_o, fault_o and mem_req_o at 0 and the base frame at 0. Reset is also honoured in the middle of a walk.
- R10: mem_req_o stays high with a stable mem_addr_o until mem_rvalid_i is seen. The walk result does not depend on the response latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Base register write strobe, honoured only when idle |
| base_wdata_i | input | 32 | Physical address of the directory; low 12 bits dropped |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Walker idle, request will be taken |
| mem_req_o | output | 1 | Memory read request, held until response |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_rvalid_i | input | 1 | Memory read response strobe |
| mem_rdata_i | input | 32 | Entry data returned by memory |
| done_o | output | 1 | One-cycle walk completion strobe |
| fault_o | output | 1 | Walk ended on an invalid entry (qualified by done_o) |
| paddr_o | output | 32 | Translated physical address (qualified by done_o) |

## Verification
Most internal errors show up as a wrong memory address. The bench memory answers any unexpected address with an entry whose valid bit is clear, so a bad index or frame selection appears as a fault on the done strobe of that same walk. A sequencer that fails to skip the second read, or that accepts a request while busy, shows as a wrong read count when the walk ends. A base register that takes writes during a walk corrupts the first read address of the next walk. A done strobe that is stuck high or repeats shows in the cycle right after the strobe.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned AW        = 32;
  localparam int unsigned OFF_W     = 12;
  localparam int unsigned IDX_W     = 10;
  localparam int unsigned ESZ_LOG   = 2;
  localparam int unsigned VALID_BIT = 0;
  localparam int unsigned PFN_W     = AW - OFF_W;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_DIR = 2'd1,
    ST_RD_TBL = 2'd2,
    ST_DONE   = 2'd3
  } walk_st_e;

  typedef struct packed {
    logic [IDX_W-1:0] dir;
    logic [IDX_W-1:0] tbl;
    logic [OFF_W-1:0] off;
  } va_t;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_valid_i,
  input  logic     rsp_valid_i,
  input  logic     entry_ok_i,
  output walk_st_e st_o,
  output logic     ready_o,
  output logic     mem_req_o,
  output logic     load_dir_o,
  output logic     fin_o,
  output logic     fin_fault_o
);
  walk_st_e st_q, st_d;
  logic     reading;

  assign reading     = (st_q == ST_RD_DIR) || (st_q == ST_RD_TBL);
  assign ready_o     = (st_q == ST_IDLE);
  assign mem_req_o   = reading;
  assign load_dir_o  = (st_q == ST_RD_DIR) && rsp_valid_i && entry_ok_i;
  // walk ends on any invalid entry, or on any leaf response
  assign fin_o       = reading && rsp_valid_i && (!entry_ok_i || (st_q == ST_RD_TBL));
  assign fin_fault_o = fin_o && !entry_ok_i;
  assign st_o        = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_valid_i) st_d = ST_RD_DIR;
      ST_RD_DIR: if (rsp_valid_i) st_d = entry_ok_i ? ST_RD_TBL : ST_DONE;
      ST_RD_TBL: if (rsp_valid_i) st_d = ST_DONE;
      ST_DONE:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/ptw_addr.sv
module ptw_addr
  import ptw_pkg::*;
(
  input  walk_st_e         st_i,
  input  logic [PFN_W-1:0] base_pfn_i,
  input  logic [PFN_W-1:0] dir_pfn_i,
  input  va_t              va_i,
  output logic [AW-1:0]    addr_o
);
  localparam int unsigned IOFF_W = IDX_W + ESZ_LOG;

  logic [PFN_W-1:0] frame;
  logic [IDX_W-1:0] idx;

  always_comb begin
    if (st_i == ST_RD_TBL) begin
      frame = dir_pfn_i;
      idx   = va_i.tbl;
    end else begin
      frame = base_pfn_i;
      idx   = va_i.dir;
    end
  end

  generate
    if (IOFF_W <= OFF_W) begin : g_concat
      // entry offset fits inside the page: no carry into the frame
      assign addr_o = {frame, {(OFF_W - IOFF_W){1'b0}}, idx, {ESZ_LOG{1'b0}}};
    end else begin : g_add
      assign addr_o = {frame, {OFF_W{1'b0}}} + AW'({idx, {ESZ_LOG{1'b0}}});
    end
  endgenerate
endmodule

// File: rtl/ptw_result.sv
module ptw_result
  import ptw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fin_i,
  input  logic             fault_i,
  input  logic [PFN_W-1:0] pfn_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             done_o,
  output logic             fault_o,
  output logic [AW-1:0]    paddr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      paddr_o <= '0;
    end else begin
      done_o  <= fin_i;
      fault_o <= fin_i && fault_i;
      paddr_o <= (fin_i && !fault_i) ? {pfn_i, off_i} : '0;
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_wdata_i,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_vaddr_i,
  output logic          req_ready_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          fault_o,
  output logic [AW-1:0] paddr_o
);
  walk_st_e         st;
  va_t              va_q;
  logic [PFN_W-1:0] base_pfn_q;
  logic [PFN_W-1:0] dir_pfn_q;
  logic             entry_ok;
  logic [PFN_W-1:0] entry_pfn;
  logic             load_dir, fin, fin_fault;

  assign entry_ok  = mem_rdata_i[VALID_BIT];
  assign entry_pfn = mem_rdata_i[AW-1:OFF_W];

  ptw_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .rsp_valid_i (mem_rvalid_i),
    .entry_ok_i  (entry_ok),
    .st_o        (st),
    .ready_o     (req_ready_o),
    .mem_req_o   (mem_req_o),
    .load_dir_o  (load_dir),
    .fin_o       (fin),
    .fin_fault_o (fin_fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_pfn_q <= '0;
      va_q       <= '0;
      dir_pfn_q  <= '0;
    end else begin
      if (base_we_i && st == ST_IDLE) base_pfn_q <= base_wdata_i[AW-1:OFF_W];
      if (req_valid_i && st == ST_IDLE) va_q <= va_t'(req_vaddr_i);
      if (load_dir) dir_pfn_q <= entry_pfn;
    end
  end

  ptw_addr u_addr (
    .st_i       (st),
    .base_pfn_i (base_pfn_q),
    .dir_pfn_i  (dir_pfn_q),
    .va_i       (va_q),
    .addr_o     (mem_addr_o)
  );

  ptw_result u_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fin_i   (fin),
    .fault_i (fin_fault),
    .pfn_i   (entry_pfn),
    .off_i   (va_q.off),
    .done_o  (done_o),
    .fault_o (fault_o),
    .paddr_o (paddr_o)
  );
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk
  import ptw_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             mem_req_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic             mem_rvalid_i,
  input logic [AW-1:0]    mem_rdata_i,
  input logic             done_o,
  input logic             fault_o,
  input logic [AW-1:0]    paddr_o,
  input logic [PFN_W-1:0] base_pfn_q
);
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_fault_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !fault_o);

  a_r5_fault_no_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (paddr_o == '0));

  a_r4_invalid_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i && !mem_rdata_i[VALID_BIT]) |=> (done_o && fault_o));

  a_r7_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && req_valid_i) |=> (mem_req_o && !req_ready_o));

  a_r8_base_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> $stable(base_pfn_q));

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o);
endmodule

bind pt_walker ptw_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .mem_rdata_i  (mem_rdata_i),
  .done_o       (done_o),
  .fault_o      (fault_o),
  .paddr_o      (paddr_o),
  .base_pfn_q   (base_pfn_q)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] pdea;
    logic [31:0] pde;
    logic [31:0] ptea;
    logic [31:0] pte;
    logic        flt;
    logic [31:0] pa;
    logic [1:0]  nrd;
  } vec_t;

  // base frame 0x00123 for all table rows
  localparam vec_t VECS [NVEC] = '{
    '{32'h0040_1ABC, 32'h0012_3004, 32'h0045_6001, 32'h0045_6004, 32'h89AB_C003, 1'b0, 32'h89AB_CABC, 2'd2},
    '{32'hFFFF_FFFF, 32'h0012_3FFC, 32'h7770_0001, 32'h7770_0FFC, 32'hFFFF_F001, 1'b0, 32'hFFFF_FFFF, 2'd2},
    '{32'h0000_0000, 32'h0012_3000, 32'h0000_1FFF, 32'h0000_1000, 32'h0000_0001, 1'b0, 32'h0000_0000, 2'd2},
    '{32'h1234_5678, 32'h0012_3120, 32'hABCD_E000, 32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_0000, 2'd1},
    '{32'h8000_3010, 32'h0012_3800, 32'h0BEE_F001, 32'h0BEE_F00C, 32'h1234_5FFE, 1'b1, 32'h0000_0000, 2'd2},
    '{32'h0ABC_D123, 32'h0012_30A8, 32'h00C0_0801, 32'h00C0_0F34, 32'h5555_5001, 1'b0, 32'h5555_5123, 2'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, fault;
  logic [31:0] paddr;

  int checks = 0;
  int errors = 0;
  int reads  = 0;
  int lat    = 0;
  int lat_cnt = 0;
  logic [31:0] m_pdea, m_pde, m_ptea, m_pte;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .base_we_i    (base_we),
    .base_wdata_i (base_wdata),
    .req_valid_i  (req_valid),
    .req_vaddr_i  (req_vaddr),
    .req_ready_o  (req_ready),
    .mem_req_o    (mem_req),
    .mem_addr_o   (mem_addr),
    .mem_rvalid_i (mem_rvalid),
    .mem_rdata_i  (mem_rdata),
    .done_o       (done),
    .fault_o      (fault),
    .paddr_o      (paddr)
  );

  // memory model: unknown addresses return an invalid entry
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid = 1'b0;
      lat_cnt = 0;
    end else if (mem_rvalid) begin
      mem_rvalid = 1'b0;
      lat_cnt = 0;
    end else if (mem_req) begin
      if (lat_cnt >= lat) begin
        mem_rvalid = 1'b1;
        reads++;
        if (mem_addr == m_pdea)      mem_rdata = m_pde;
        else if (mem_addr == m_ptea) mem_rdata = m_pte;
        else                         mem_rdata = 32'hDEAD_BEE0;
      end else lat_cnt++;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk); base_we = 1'b1; base_wdata = b;
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic walk(input vec_t v, input string req);
    int n;
    m_pdea = v.pdea; m_pde = v.pde; m_ptea = v.ptea; m_pte = v.pte;
    reads = 0;
    @(negedge clk); req_valid = 1'b1; req_vaddr = v.va;
    @(negedge clk); req_valid = 1'b0;
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    chk(done == 1'b1, {req, " done"}, 32'(done), 32'd1);
    chk(fault == v.flt, {req, " fault"}, 32'(fault), 32'(v.flt));
    chk(paddr == v.pa, {req, " paddr"}, paddr, v.pa);
    chk(reads == int'(v.nrd), {req, " reads"}, 32'(reads), 32'(v.nrd));
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", 32'(done), 32'd0);
    chk(fault == 1'b0, "R6 fault cleared", 32'(fault), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    vec_t v;
    m_pdea = '1; m_pde = '0; m_ptea = '1; m_pte = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(req_ready == 1'b1, "R9 ready in reset", 32'(req_ready), 32'd1);
    chk(done == 1'b0, "R9 done in reset", 32'(done), 32'd0);
    chk(fault == 1'b0, "R9 fault in reset", 32'(fault), 32'd0);
    chk(mem_req == 1'b0, "R9 mem_req in reset", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    set_base(32'h0012_3ABC);

    // R1 R2 R3 R4 R5 R10 over the table, latency varied
    for (int i = 0; i < NVEC; i++) begin
      lat = i % 3;
      walk(VECS[i], VECS[i].flt ? "R4_R5 fault walk" : "R1_R2_R3 walk");
    end

    // R10 long latency
    lat = 5;
    walk(VECS[5], "R10 slow memory");

    // R7 R8: request and base write while busy are ignored
    lat = 4;
    v = VECS[0];
    m_pdea = v.pdea; m_pde = v.pde; m_ptea = v.ptea; m_pte = v.pte;
    reads = 0;
    @(negedge clk); req_valid = 1'b1; req_vaddr = v.va;
    @(negedge clk); req_vaddr = 32'h1234_5678; base_we = 1'b1; base_wdata = 32'h00AB_C000;
    chk(req_ready == 1'b0, "R7 busy not ready", 32'(req_ready), 32'd0);
    @(negedge clk);
    @(negedge clk); req_valid = 1'b0; base_we = 1'b0;
    for (int n = 0; n < 100 && !done; n++) @(negedge clk);
    chk(paddr == v.pa, "R7 busy request ignored", paddr, v.pa);
    chk(reads == 2, "R7 read count", 32'(reads), 32'd2);
    @(negedge clk);
    lat = 1;
    walk(VECS[0], "R8 base kept after busy write");

    // R8 idle write applies; low bits dropped
    set_base(32'h00AB_C5A5);
    v = '{32'h00C0_2345, 32'h00AB_C00C, 32'h0010_0001, 32'h0010_0008, 32'hCAFE_B001, 1'b0, 32'hCAFE_B345, 2'd2};
    walk(v, "R8 idle base write");

    // R9 reset mid walk
    lat = 10;
    @(negedge clk); req_valid = 1'b1; req_vaddr = VECS[1].va;
    @(negedge clk); req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(req_ready == 1'b1, "R9 idle after mid-walk reset", 32'(req_ready), 32'd1);
    chk(mem_req == 1'b0, "R9 no request after reset", 32'(mem_req), 32'd0);
    chk(done == 1'b0, "R9 no done after reset", 32'(done), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    lat = 0;
    v = '{32'h0000_1004, 32'h0000_0000, 32'h0000_2001, 32'h0000_2004, 32'h0000_3001, 1'b0, 32'h0000_3004, 2'd2};
    walk(v, "R9 base zero after reset");

    summary();
  end
endmodule